// File: doc/BRIEF.md
# NAND Cache-Register Stream Sequencer

This block drives an 8-bit multiplexed NAND bus to move a run of consecutive pages in either direction, using the device's cache register so that array time overlaps bus time. A host starts it with a direction, a page count and a five-byte start address. It then exchanges page bytes through valid/ready streams, and gets a one-cycle completion pulse with a pass/fail flag.

A read run opens the first page in the usual way. For every later page, the block sends only a short continue opcode before draining the page just moved into the cache register, so the device fetches the following page while the bytes go out. No further address bytes are sent. The final page gets a distinct closing opcode. A program run loads each page with its own address and sends a cache-program opcode. It waits only for the short register-copy busy period, then loads the next page. The last page is committed with the ordinary confirm opcode, and a single status read settles the result. A run of one page uses the plain command flow.

Top module: `nand_cache_seq`

## Requirements
- R1: A read run begins with opcode 00h, then five address cycles sent low byte first (bytes 0 and 1 are the column, bytes 2 to 4 the row), then opcode 30h.
- R2: In a read run of more than one page, opcode 31h precedes the data-out of every page except the last, opcode 3Fh precedes the data-out of the last page, and no address cycle follows the first five.
- R3: A run with a page count of 1 uses no cache opcode (no 31h, 3Fh or 15h). A read is 00h, address, 30h, data-out. A program is 80h, address, data-in, 10h, 70h.
- R4: Read data reaches the host in order, PAGE_BYTES bytes per page, where byte k of page p equals what the device returned for it. A bus read strobe is issued only when the output slot is empty or is being taken in that cycle. A held output byte stays stable.
- R5: In a program run, each page is opened with 80h and five address cycles whose row field equals the start row plus the page index, and is followed by PAGE_BYTES host bytes in order. It is then closed by 15h when more pages follow, or by 10h for the last page.
- R6: After each of 30h, 31h, 3Fh, 15h and 10h, no bus cycle of any kind occurs until GUARD cycles have passed and the ready input is high.
- R7: After the final 10h and ready, the block issues 70h and one status read. failFlag is set to status bit 0 OR status bit 1, where bit 1 carries the result of an earlier cached page.
- R8: After reset, busy, done, inReady and outValid are low. busy is high from the cycle after start until done. done pulses for exactly one cycle, and busy is low in the following cycle.
- R9: Command latch and address latch are never high together, and the write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a run (sampled while idle) |
| isProgram | input | 1 | 1 = program run, 0 = read run |
| pageCount | input | CNT_W | Number of pages, at least 1 |
| startAddr | input | 8*ADDR_CYCLES | Column bytes then row bytes |
| inData | input | 8 | Host write byte |
| inValid | input | 1 | Host write byte valid |
| inReady | output | 1 | Block accepts a write byte |
| outData | output | 8 | Read byte to host |
| outValid | output | 1 | Read byte valid |
| outReady | input | 1 | Host accepts read byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| failFlag | output | 1 | Program status failure |
| nandIoOut | output | 8 | Bus byte driven to device |
| nandIoIn | input | 8 | Bus byte from device |
| nandOe | output | 1 | Bus output enable |
| nandCle | output | 1 | Command latch |
| nandAle | output | 1 | Address latch |
| nandWe | output | 1 | Write strobe, one bus cycle |
| nandRe | output | 1 | Read strobe, one bus cycle |
| nandReady | input | 1 | Device ready |

## Verification
The hardest case to reach is a host that withholds ready while the sequencer is draining a cache page. That pause must hold off the bus read strobe without losing or repeating a byte. The continue and close opcodes must still come out in the right order at the page boundary. The stimulus toggles outReady on an irregular pattern across a multi-page read, and gaps inValid during a multi-page program, so stalls fall on the first, middle and last byte of pages. A status byte carrying only the earlier-page failure bit checks that a cached page's failure reaches the flag.

// File: rtl/nand_cache_pkg.sv
package nand_cache_pkg;
  localparam logic [7:0] OP_READ       = 8'h00;
  localparam logic [7:0] OP_READ_GO    = 8'h30;
  localparam logic [7:0] OP_CACHE_NEXT = 8'h31;
  localparam logic [7:0] OP_CACHE_LAST = 8'h3F;
  localparam logic [7:0] OP_PROG       = 8'h80;
  localparam logic [7:0] OP_CACHE_PROG = 8'h15;
  localparam logic [7:0] OP_PROG_GO    = 8'h10;
  localparam logic [7:0] OP_STATUS     = 8'h70;

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_ADDR, S_GO, S_WAIT, S_CACHECMD, S_DRAIN,
    S_FLUSH, S_LOAD, S_COMMIT, S_STCMD, S_STREAD, S_FIN
  } seqState_t;

  typedef struct packed {
    logic       load;
    logic       cmdEn;
    logic [7:0] cmdCode;
    logic       addrEn;
    logic       wrEn;
    logic       rdData;
    logic       rdStat;
    logic       pageNext;
  } seqStrobes_t;
endpackage

// File: rtl/nand_cache_ctrl.sv
module nand_cache_ctrl
  import nand_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isProgram,
  input  logic        inValid,
  input  logic        outFree,
  input  logic        devReady,
  input  logic        addrLast,
  input  logic        byteLast,
  input  logic        onePage,
  input  logic        guardDone,
  output seqStrobes_t strb,
  output logic        inReady,
  output logic        busy,
  output logic        done
);
  seqState_t state, nxt, retState, retNext;
  logic      progMode, setRet;

  always_comb begin
    strb    = '0;
    nxt     = state;
    retNext = retState;
    setRet  = 1'b0;
    inReady = 1'b0;
    done    = 1'b0;
    case (state)
      S_IDLE: if (start) begin strb.load = 1'b1; nxt = S_OPEN; end
      S_OPEN: begin
        strb.cmdEn = 1'b1; strb.cmdCode = progMode ? OP_PROG : OP_READ;
        nxt = S_ADDR;
      end
      S_ADDR: begin
        strb.addrEn = 1'b1;
        if (addrLast) nxt = progMode ? S_LOAD : S_GO;
      end
      S_GO: begin
        strb.cmdEn = 1'b1; strb.cmdCode = OP_READ_GO;
        nxt = S_WAIT; setRet = 1'b1;
        retNext = onePage ? S_DRAIN : S_CACHECMD;
      end
      S_WAIT: if (guardDone && devReady) nxt = retState;
      S_CACHECMD: begin
        strb.cmdEn = 1'b1; strb.cmdCode = onePage ? OP_CACHE_LAST : OP_CACHE_NEXT;
        nxt = S_WAIT; setRet = 1'b1; retNext = S_DRAIN;
      end
      S_DRAIN: if (outFree) begin
        strb.rdData = 1'b1;
        if (byteLast) begin
          strb.pageNext = 1'b1;
          nxt = onePage ? S_FLUSH : S_CACHECMD;
        end
      end
      S_FLUSH: if (outFree) nxt = S_FIN;
      S_LOAD: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.wrEn = 1'b1;
          if (byteLast) nxt = S_COMMIT;
        end
      end
      S_COMMIT: begin
        strb.cmdEn = 1'b1; strb.cmdCode = onePage ? OP_PROG_GO : OP_CACHE_PROG;
        strb.pageNext = 1'b1;
        nxt = S_WAIT; setRet = 1'b1;
        retNext = onePage ? S_STCMD : S_OPEN;
      end
      S_STCMD: begin
        strb.cmdEn = 1'b1; strb.cmdCode = OP_STATUS; nxt = S_STREAD;
      end
      S_STREAD: begin strb.rdStat = 1'b1; nxt = S_FIN; end
      S_FIN: begin done = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
      progMode <= 1'b0;
    end else begin
      state <= nxt;
      if (setRet) retState <= retNext;
      if (strb.load) progMode <= isProgram;
    end
  end

  assign busy = (state != S_IDLE);

  // R8: run ends in idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R8: accepted start makes the block busy
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  // R6: the cycle after an array-starting opcode is always a wait cycle
  p_wait_after_go_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdEn && strb.cmdCode != OP_STATUS && strb.cmdCode != OP_READ
     && strb.cmdCode != OP_PROG) |=> (state == S_WAIT));
endmodule

// File: rtl/nand_cache_dp.sv
module nand_cache_dp
  import nand_cache_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int COL_CYCLES  = 2,
  parameter int PAGE_BYTES  = 8,
  parameter int CNT_W       = 8,
  parameter int GUARD       = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobes_t              strb,
  input  logic [8*ADDR_CYCLES-1:0] startAddr,
  input  logic [CNT_W-1:0]         pageCount,
  input  logic [7:0]               inData,
  input  logic [7:0]               busIn,
  input  logic                     outReady,
  input  logic                     devReady,
  output logic [7:0]               busOut,
  output logic                     busOe,
  output logic                     cle,
  output logic                     ale,
  output logic                     weStrobe,
  output logic                     reStrobe,
  output logic [7:0]               outData,
  output logic                     outValid,
  output logic                     outFree,
  output logic                     failFlag,
  output logic                     addrLast,
  output logic                     byteLast,
  output logic                     onePage,
  output logic                     guardDone
);
  localparam int ADDR_W  = 8 * ADDR_CYCLES;
  localparam int ROW_LSB = 8 * COL_CYCLES;
  localparam int ROW_W   = ADDR_W - ROW_LSB;
  localparam int AIDX_W  = $clog2(ADDR_CYCLES);
  localparam int BCNT_W  = $clog2(PAGE_BYTES);
  localparam int GCNT_W  = $clog2(GUARD + 1);

  logic [ADDR_W-1:0] curAddr, shiftAddr, nextAddr;
  logic [AIDX_W-1:0] addrIdx;
  logic [BCNT_W-1:0] byteCnt;
  logic [CNT_W-1:0]  pagesLeft;
  logic [GCNT_W-1:0] guardCnt;

  assign nextAddr  = {curAddr[ADDR_W-1:ROW_LSB] + ROW_W'(1), curAddr[ROW_LSB-1:0]};
  assign addrLast  = (addrIdx == AIDX_W'(ADDR_CYCLES - 1));
  assign byteLast  = (byteCnt == BCNT_W'(PAGE_BYTES - 1));
  assign onePage   = (pagesLeft == CNT_W'(1));
  assign guardDone = (guardCnt == GCNT_W'(GUARD));
  assign outFree   = !outValid || outReady;

  assign cle      = strb.cmdEn;
  assign ale      = strb.addrEn;
  assign weStrobe = strb.cmdEn | strb.addrEn | strb.wrEn;
  assign reStrobe = strb.rdData | strb.rdStat;
  assign busOe    = weStrobe;
  assign busOut   = strb.cmdEn ? strb.cmdCode : (strb.addrEn ? shiftAddr[7:0] : inData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0; shiftAddr <= '0; addrIdx <= '0; byteCnt <= '0;
      pagesLeft <= '0; guardCnt <= GCNT_W'(GUARD);
      outData <= '0; outValid <= 1'b0; failFlag <= 1'b0;
    end else begin
      if (strb.load) begin
        curAddr <= startAddr; shiftAddr <= startAddr; addrIdx <= '0;
        byteCnt <= '0; pagesLeft <= pageCount; failFlag <= 1'b0;
      end else if (strb.pageNext) begin
        curAddr <= nextAddr; shiftAddr <= nextAddr; addrIdx <= '0;
        byteCnt <= '0; pagesLeft <= pagesLeft - CNT_W'(1);
      end else begin
        if (strb.addrEn) begin
          shiftAddr <= shiftAddr >> 8;
          addrIdx   <= addrIdx + AIDX_W'(1);
        end
        if (strb.wrEn || strb.rdData) byteCnt <= byteCnt + BCNT_W'(1);
      end

      if (strb.cmdEn) guardCnt <= '0;
      else if (!guardDone) guardCnt <= guardCnt + GCNT_W'(1);

      if (strb.rdData) begin
        outData <= busIn; outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end

      if (strb.rdStat) failFlag <= busIn[0] | busIn[1];
    end
  end

  // R9: bus cycle kinds are exclusive
  p_latch_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale) && !(weStrobe && reStrobe));
  // R6: data moves only while the device is ready
  p_xfer_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn || strb.rdData || strb.rdStat) |-> devReady);
  // R4: no bus read while the host holds a byte
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !strb.rdData);
  // R4: a held byte stays put
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: rtl/nand_cache_seq.sv
module nand_cache_seq
  import nand_cache_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int COL_CYCLES  = 2,
  parameter int PAGE_BYTES  = 8,
  parameter int CNT_W       = 8,
  parameter int GUARD       = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     isProgram,
  input  logic [CNT_W-1:0]         pageCount,
  input  logic [8*ADDR_CYCLES-1:0] startAddr,
  input  logic [7:0]               inData,
  input  logic                     inValid,
  output logic                     inReady,
  output logic [7:0]               outData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     busy,
  output logic                     done,
  output logic                     failFlag,
  output logic [7:0]               nandIoOut,
  input  logic [7:0]               nandIoIn,
  output logic                     nandOe,
  output logic                     nandCle,
  output logic                     nandAle,
  output logic                     nandWe,
  output logic                     nandRe,
  input  logic                     nandReady
);
  seqStrobes_t strb;
  logic outFree, addrLast, byteLast, onePage, guardDone;

  nand_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isProgram(isProgram),
    .inValid(inValid), .outFree(outFree), .devReady(nandReady),
    .addrLast(addrLast), .byteLast(byteLast), .onePage(onePage),
    .guardDone(guardDone), .strb(strb), .inReady(inReady),
    .busy(busy), .done(done)
  );

  nand_cache_dp #(
    .ADDR_CYCLES(ADDR_CYCLES), .COL_CYCLES(COL_CYCLES),
    .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .GUARD(GUARD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .pageCount(pageCount), .inData(inData), .busIn(nandIoIn),
    .outReady(outReady), .devReady(nandReady), .busOut(nandIoOut),
    .busOe(nandOe), .cle(nandCle), .ale(nandAle), .weStrobe(nandWe),
    .reStrobe(nandRe), .outData(outData), .outValid(outValid),
    .outFree(outFree), .failFlag(failFlag), .addrLast(addrLast),
    .byteLast(byteLast), .onePage(onePage), .guardDone(guardDone)
  );
endmodule

// File: tb/nand_cache_seq_test.sv
module nand_cache_seq_test;
  localparam int PB = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, isProgram, inValid, inReady, outValid, outReady;
  logic busy, done, failFlag, nandOe, nandCle, nandAle, nandWe, nandRe, nandReady;
  logic [7:0] pageCount, inData, outData, nandIoOut, nandIoIn;
  logic [39:0] startAddr;

  nand_cache_seq uut (.*);

  int nChk = 0, nFail = 0;
  logic [7:0] cmdLog [0:63];
  logic [7:0] addrLog[0:63];
  logic [7:0] wrLog  [0:63];
  logic [7:0] rdLog  [0:63];
  int nCmd, nAddr, nWr, nRd, readyViol, laneViol, busyCnt, addrPos, rdIdx;
  logic [7:0] statVal, curRow, nextPg, xferPg;
  logic statMode;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device model, acting mid-cycle
  always @(negedge clk) begin
    if ((nandWe || nandRe) && !nandReady) readyViol++;
    if ((nandCle && nandAle) || (nandWe && nandRe)) laneViol++;
    if (busyCnt > 0) begin
      busyCnt--;
      if (busyCnt == 0) nandReady = 1'b1;
    end
    if (nandWe && nandCle) begin
      cmdLog[nCmd[5:0]] = nandIoOut; nCmd++; addrPos = 0;
      case (nandIoOut)
        8'h30: begin nextPg = curRow; xferPg = curRow; rdIdx = 0; end
        8'h31, 8'h3F: begin xferPg = nextPg; nextPg = nextPg + 8'd1; rdIdx = 0; end
        8'h70: statMode = 1'b1;
        8'h00: statMode = 1'b0;
        default: ;
      endcase
      if (nandIoOut inside {8'h30, 8'h31, 8'h3F, 8'h15, 8'h10}) begin
        nandReady = 1'b0; busyCnt = 6;
      end
    end else if (nandWe && nandAle) begin
      addrLog[nAddr[5:0]] = nandIoOut; nAddr++;
      if (addrPos == 2) curRow = nandIoOut;
      addrPos++;
    end else if (nandWe) begin
      wrLog[nWr[5:0]] = nandIoOut; nWr++;
    end
    if (nandRe) begin
      nandIoIn = statMode ? statVal : {xferPg[3:0], 4'(rdIdx)};
      rdIdx++;
    end
  end

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  // start a run and service the host side until done
  task automatic runOp(bit prog, int n, logic [7:0] row, bit stall, logic [7:0] stat);
    int cyc = 0, wIdx = 0, idleBusy = 0;
    bit seen = 0;
    @(negedge clk);
    nCmd = 0; nAddr = 0; nWr = 0; nRd = 0; readyViol = 0; laneViol = 0;
    statVal = stat; isProgram = prog; pageCount = 8'(n);
    startAddr = {8'h00, 8'h12, row, 8'h00, 8'h40};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen && cyc < 4000) begin
      outReady = stall ? (cyc % 3 == 1) : 1'b1;
      if (outValid && outReady) begin rdLog[nRd[5:0]] = outData; nRd++; end
      inValid = stall ? (cyc % 2 == 0) : 1'b1;
      inData  = pat(wIdx);
      if (inValid && inReady) wIdx++;
      if (done) seen = 1;
      else if (!busy) idleBusy++;
      cyc++;
      if (!seen) @(negedge clk);
    end
    check(seen, "R8", "watchdog done seen", int'(seen), 1);
    check(idleBusy == 0, "R8", "busy low during run", idleBusy, 0);
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b0;
    check(!busy && !done, "R8", "idle after done pulse", {busy, done}, 0);
    check(readyViol == 0, "R6", "bus cycles while busy", readyViol, 0);
    check(laneViol == 0, "R9", "overlapping bus cycle kinds", laneViol, 0);
  endtask

  task automatic checkCmds(string req, logic [7:0] exp[], int nExp);
    int bad = -1;
    for (int i = 0; i < nExp; i++) if (bad < 0 && cmdLog[i] != exp[i]) bad = i;
    check(nCmd == nExp, req, "opcode count", nCmd, nExp);
    check(bad < 0, req, "opcode order", (bad < 0) ? 0 : int'(cmdLog[bad]),
          (bad < 0) ? 0 : int'(exp[bad]));
  endtask

  task automatic checkReadData(string req, int n, logic [7:0] row);
    int bad = 0;
    for (int p = 0; p < n; p++)
      for (int k = 0; k < PB; k++)
        if (rdLog[p*PB+k] != {4'(row + 8'(p)), 4'(k)}) bad++;
    check(nRd == n * PB, req, "read byte count", nRd, n * PB);
    check(bad == 0, req, "read byte values", bad, 0);
  endtask

  task automatic testReset();
    check(!busy && !done, "R8", "reset busy/done", {busy, done}, 0);
    check(!inReady && !outValid, "R8", "reset handshakes", {inReady, outValid}, 0);
    check(!nandCle && !nandAle && !nandWe && !nandRe, "R9", "reset bus idle",
          {nandCle, nandAle, nandWe, nandRe}, 0);
  endtask

  task automatic testReadPlain();
    logic [7:0] e[] = '{8'h00, 8'h30};
    runOp(0, 1, 8'h05, 0, 8'h00);
    checkCmds("R3", e, 2);
    check(nAddr == 5 && addrLog[0] == 8'h40 && addrLog[2] == 8'h05 && addrLog[3] == 8'h12,
          "R1", "address cycles", nAddr, 5);
    checkReadData("R4", 1, 8'h05);
  endtask

  task automatic testReadStream();
    logic [7:0] e[] = '{8'h00, 8'h30, 8'h31, 8'h31, 8'h31, 8'h3F};
    runOp(0, 4, 8'h09, 0, 8'h00);
    checkCmds("R2", e, 6);
    check(nAddr == 5, "R2", "no address after first page", nAddr, 5);
    checkReadData("R2", 4, 8'h09);
  endtask

  task automatic testReadStall();
    logic [7:0] e[] = '{8'h00, 8'h30, 8'h31, 8'h31, 8'h3F};
    runOp(0, 3, 8'h0C, 1, 8'h00);
    checkCmds("R2", e, 5);
    checkReadData("R4", 3, 8'h0C);
  endtask

  task automatic testProg(string req, int n, logic [7:0] row, bit stall,
                          logic [7:0] stat, bit expFail);
    logic [7:0] e[] = new[2 * n + 1];
    int bad = 0;
    for (int p = 0; p < n; p++) begin
      e[2*p] = 8'h80;
      e[2*p+1] = (p == n - 1) ? 8'h10 : 8'h15;
    end
    e[2*n] = 8'h70;
    runOp(1, n, row, stall, stat);
    checkCmds((n == 1) ? "R3" : "R5", e, 2 * n + 1);
    for (int p = 0; p < n; p++)
      if (addrLog[p*5+2] != row + 8'(p) || addrLog[p*5] != 8'h40) bad++;
    check(nAddr == 5 * n && bad == 0, "R5", "per-page row address", bad, 0);
    bad = 0;
    for (int i = 0; i < n * PB; i++) if (wrLog[i] != pat(i)) bad++;
    check(nWr == n * PB && bad == 0, "R5", "program data bytes", nWr, n * PB);
    check(failFlag == expFail, req, "status fail flag", int'(failFlag), int'(expFail));
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; isProgram = 1'b0; pageCount = '0; startAddr = '0;
    inData = '0; inValid = 1'b0; outReady = 1'b1; nandIoIn = '0; nandReady = 1'b1;
    busyCnt = 0; statMode = 1'b0; statVal = '0; curRow = '0; nextPg = '0; xferPg = '0;
    addrPos = 0; rdIdx = 0; nCmd = 0; nAddr = 0; nWr = 0; nRd = 0;
    readyViol = 0; laneViol = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReadPlain();
    testReadStream();
    testReadStall();
    testProg("R7", 1, 8'h30, 0, 8'hE0, 0);
    testProg("R7", 3, 8'h20, 1, 8'hE0, 0);
    testProg("R7", 2, 8'h40, 0, 8'hE2, 1);
    testProg("R7", 1, 8'h50, 0, 8'hE1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule